// File: doc/BRIEF.md
# Per-Domain Split Counter Read Port

This block lets several independent owners (domains) read a wide free-running system counter through a 32-bit data path. Each read takes two accesses: a low-word read that returns counter bits 31:0, and a high-word read that returns the remaining upper bits. Between those two accesses the low word may roll over, which would make the combined value wrong. The high-word result therefore carries a per-domain overflow flag. Software uses it to detect such a torn read and retry.

Each domain keeps its own sticky wrap bit. A low read by that domain clears it. Any cycle in which the counter's low 32 bits step from all-ones to zero sets it. High reads only report the bit and leave it unchanged. The counter is an input to this block. A read is requested with a strobe, a domain index and a word select. The result appears on a registered data output one cycle later, together with a valid pulse.

Top module: `cntrd_top`

## Requirements
- R1: A low read (word select 0) of an in-range domain returns counter bits 31:0, as sampled in the strobe cycle, on `rdData` in the next cycle.
- R2: A high read (word select 1) returns counter bits CNT_WIDTH-1:32 in `rdData[CNT_WIDTH-33:0]`. Bits 29 down to CNT_WIDTH-32 read as zero.
- R3: Bit 30 of every high read (the busy bit) is 0.
- R4: Bit 31 of a high read (the overflow flag) is 1 when the counter's low word stepped from 0xFFFFFFFF to 0 in any cycle after that domain's last low read, up to and including the strobe cycle. Otherwise it is 0.
- R5: A low read clears its domain's wrap bit. When a wrap and a low read of the same domain fall in the same cycle, the clear wins.
- R6: High reads do not clear the wrap bit. Repeated high reads after a wrap keep reporting overflow until the next low read.
- R7: Each domain's wrap bit is independent. A low read by one domain leaves the flag seen by the other domains unchanged.
- R8: A read with a domain index at or above NUM_DOMAINS returns zero and changes no wrap bit.
- R9: Reset drives `rdValid` and `rdData` to 0 and clears every domain's wrap bit.
- R10: `rdValid` is high exactly one cycle after each strobe, including out-of-range strobes. `rdData` is 0 whenever `rdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| counterIn | input | CNT_WIDTH | Free-running system counter value |
| rdStrobe | input | 1 | Read request, one cycle per access |
| rdDomain | input | DOM_W | Domain index of the read |
| rdHigh | input | 1 | Word select: 0 low word, 1 high word |
| rdData | output | 32 | Registered read result |
| rdValid | output | 1 | High one cycle after a strobe |

## Verification
The bound checker tests the following on every cycle:
- the one-cycle strobe-to-valid timing;
- that the low word and the masked high bits match the counter value from the strobe cycle;
- that the busy bit is always clear;
- that out-of-range reads return zero;
- that a high read in a cycle where the low word wraps reports overflow.

Properties that depend on a history of accesses can only be shown by the bench's ordered scenarios. These are:
- stickiness across several high reads;
- the clear on a low read, and its priority over a simultaneous wrap;
- independence between domains;
- out-of-range reads leaving the wrap state untouched;
- reset clearing a pending flag.

// File: rtl/cntrd_pkg.sv
package cntrd_pkg;
  localparam int WORD_W   = 32;
  localparam int OVF_BIT  = 31;
  localparam int BUSY_BIT = 30;

  // Strobes from control to datapath
  typedef struct packed {
    logic strobe;   // any read request this cycle
    logic inRange;  // domain index is implemented
    logic selHigh;  // high word requested
  } rdCmd_t;
endpackage

// File: rtl/cntrd_ctrl.sv
module cntrd_ctrl
  import cntrd_pkg::*;
#(
  parameter int NUM_DOMAINS = 3,
  parameter int DOM_W       = 2
) (
  input  logic                   rdStrobe,
  input  logic                   rdHigh,
  input  logic [DOM_W-1:0]       rdDomain,
  output rdCmd_t                 cmd,
  output logic [NUM_DOMAINS-1:0] domSel
);
  logic inRange;

  always_comb begin
    inRange     = ({1'b0, rdDomain} < (DOM_W+1)'(NUM_DOMAINS));
    cmd.strobe  = rdStrobe;
    cmd.inRange = inRange;
    cmd.selHigh = rdHigh;
  end

  // One-hot domain select, only for valid in-range strobes
  for (genvar i = 0; i < NUM_DOMAINS; i++) begin : gSel
    assign domSel[i] = rdStrobe && inRange && (rdDomain == DOM_W'(i));
  end
endmodule

// File: rtl/cntrd_datapath.sv
module cntrd_datapath
  import cntrd_pkg::*;
#(
  parameter int CNT_WIDTH   = 48,
  parameter int NUM_DOMAINS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CNT_WIDTH-1:0]   counterIn,
  input  rdCmd_t                 cmd,
  input  logic [NUM_DOMAINS-1:0] domSel,
  output logic [WORD_W-1:0]      rdData,
  output logic                   rdValid
);
  // Upper part width; CNT_WIDTH must lie in 33..62
  localparam int HI_W = CNT_WIDTH - WORD_W;

  logic [WORD_W-1:0]      prevLow;
  logic                   wrapNow;
  logic [NUM_DOMAINS-1:0] stickyQ;
  logic                   ovfSel;
  logic [WORD_W-1:0]      hiWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLow <= '0;
    else       prevLow <= counterIn[WORD_W-1:0];
  end

  assign wrapNow = (prevLow == '1) && (counterIn[WORD_W-1:0] == '0);

  for (genvar i = 0; i < NUM_DOMAINS; i++) begin : gDom
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         stickyQ[i] <= 1'b0;
      else if (domSel[i] && !cmd.selHigh) stickyQ[i] <= 1'b0;
      else if (wrapNow)                  stickyQ[i] <= 1'b1;
    end
  end

  always_comb begin
    ovfSel = (|(stickyQ & domSel)) | (wrapNow & (|domSel));
    hiWord = '0;
    hiWord[HI_W-1:0] = counterIn[CNT_WIDTH-1:WORD_W];
    hiWord[OVF_BIT]  = ovfSel;
    hiWord[BUSY_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= cmd.strobe;
      if (cmd.strobe && cmd.inRange)
        rdData <= cmd.selHigh ? hiWord : counterIn[WORD_W-1:0];
      else
        rdData <= '0;
    end
  end
endmodule

// File: rtl/cntrd_top.sv
module cntrd_top
  import cntrd_pkg::*;
#(
  parameter int CNT_WIDTH   = 48,
  parameter int NUM_DOMAINS = 3,
  parameter int DOM_W       = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_WIDTH-1:0] counterIn,
  input  logic                 rdStrobe,
  input  logic [DOM_W-1:0]     rdDomain,
  input  logic                 rdHigh,
  output logic [31:0]          rdData,
  output logic                 rdValid
);
  rdCmd_t                 cmd;
  logic [NUM_DOMAINS-1:0] domSel;

  cntrd_ctrl #(.NUM_DOMAINS(NUM_DOMAINS), .DOM_W(DOM_W)) uCtrl (
    .rdStrobe(rdStrobe), .rdHigh(rdHigh), .rdDomain(rdDomain),
    .cmd(cmd), .domSel(domSel)
  );

  cntrd_datapath #(.CNT_WIDTH(CNT_WIDTH), .NUM_DOMAINS(NUM_DOMAINS)) uDp (
    .clk(clk), .rstN(rstN), .counterIn(counterIn), .cmd(cmd),
    .domSel(domSel), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/cntrd_checker.sv
module cntrd_checker #(
  parameter int CNT_WIDTH   = 48,
  parameter int NUM_DOMAINS = 3,
  parameter int DOM_W       = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [CNT_WIDTH-1:0] counterIn,
  input logic                 rdStrobe,
  input logic [DOM_W-1:0]     rdDomain,
  input logic                 rdHigh,
  input logic [31:0]          rdData,
  input logic                 rdValid
);
  logic okDom;
  assign okDom = (int'(rdDomain) < NUM_DOMAINS);

  // R10: valid follows strobe by one cycle
  a_r10_valid_timing: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (rdValid == $past(rdStrobe)));

  // R10: data idle at zero without valid
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == 32'd0));

  // R1: low read returns low counter bits
  a_r1_low_word: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rdStrobe && !rdHigh && okDom)
      |-> (rdData == $past(counterIn[31:0])));

  // R2: high bits masked to counter width
  a_r2_high_word: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rdStrobe && rdHigh && okDom)
      |-> (rdData[29:0] == 30'($past(counterIn) >> 32)));

  // R3: busy bit never set
  a_r3_busy_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rdStrobe && rdHigh) |-> (rdData[30] == 1'b0));

  // R8: out-of-range read returns zero
  a_r8_oor_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rdStrobe && !okDom) |-> (rdData == 32'd0));

  // R4: wrap in the strobe cycle is reported
  a_r4_wrap_seen: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rstN, 2) && $past(rdStrobe && rdHigh && okDom)
      && ($past(counterIn[31:0]) == 32'd0)
      && ($past(counterIn[31:0], 2) == 32'hFFFF_FFFF)
      |-> rdData[31]);
endmodule

bind cntrd_top cntrd_checker #(
  .CNT_WIDTH(CNT_WIDTH), .NUM_DOMAINS(NUM_DOMAINS), .DOM_W(DOM_W)
) uChk (.*);

// File: tb/sim_cntrd_top.sv
module sim_cntrd_top;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] counterIn = '0;
  logic          rdStrobe = 1'b0;
  logic [1:0]    rdDomain = '0;
  logic          rdHigh = 1'b0;
  logic [31:0]   rdData;
  logic          rdValid;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  cntrd_top #(.CNT_WIDTH(CW), .NUM_DOMAINS(3)) u0 (
    .clk(clk), .rstN(rstN), .counterIn(counterIn), .rdStrobe(rdStrobe),
    .rdDomain(rdDomain), .rdHigh(rdHigh), .rdData(rdData), .rdValid(rdValid)
  );

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          stb;
    logic [1:0]    dom;
    logic          hi;
    logic          expV;
    logic [31:0]   expD;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{48'h1234_0000_0010, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0000_0010, 4'd1},  // R1
    '{48'h1234_0000_0010, 1'b1, 2'd0, 1'b1, 1'b1, 32'h0000_1234, 4'd2},  // R2 R3
    '{48'hABCD_FFFF_FFFE, 1'b1, 2'd1, 1'b0, 1'b1, 32'hFFFF_FFFE, 4'd1},  // R1
    '{48'hABCD_FFFF_FFFF, 1'b1, 2'd2, 1'b1, 1'b1, 32'h0000_ABCD, 4'd4},  // R4 none
    '{48'hABCE_0000_0000, 1'b1, 2'd1, 1'b1, 1'b1, 32'h8000_ABCE, 4'd4},  // R4 same cycle
    '{48'hABCE_0000_0001, 1'b1, 2'd1, 1'b1, 1'b1, 32'h8000_ABCE, 4'd6},  // R6
    '{48'hABCE_0000_0002, 1'b1, 2'd1, 1'b1, 1'b1, 32'h8000_ABCE, 4'd6},  // R6
    '{48'hABCE_0000_0003, 1'b1, 2'd1, 1'b0, 1'b1, 32'h0000_0003, 4'd5},  // R5 clear
    '{48'hABCE_0000_0004, 1'b1, 2'd1, 1'b1, 1'b1, 32'h0000_ABCE, 4'd5},  // R5
    '{48'hABCE_0000_0005, 1'b1, 2'd0, 1'b1, 1'b1, 32'h8000_ABCE, 4'd7},  // R7
    '{48'hABCE_0000_0006, 1'b1, 2'd3, 1'b1, 1'b1, 32'h0000_0000, 4'd8},  // R8
    '{48'hABCE_0000_0007, 1'b1, 2'd3, 1'b0, 1'b1, 32'h0000_0000, 4'd8},  // R8
    '{48'hABCE_0000_0008, 1'b1, 2'd2, 1'b1, 1'b1, 32'h8000_ABCE, 4'd8},  // R8 state kept
    '{48'hABCE_0000_0009, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 4'd10}, // R10
    '{48'hABCE_FFFF_FFFF, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 4'd10}, // R10
    '{48'hABCF_0000_0000, 1'b1, 2'd2, 1'b0, 1'b1, 32'h0000_0000, 4'd5},  // R5 priority
    '{48'hABCF_0000_0001, 1'b1, 2'd2, 1'b1, 1'b1, 32'h0000_ABCF, 4'd5},  // R5 priority
    '{48'hABCF_0000_0002, 1'b1, 2'd0, 1'b1, 1'b1, 32'h8000_ABCF, 4'd7},  // R7
    '{48'hABCF_0000_0003, 1'b1, 2'd1, 1'b1, 1'b1, 32'h8000_ABCF, 4'd7}   // R7
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, sample just after the next posedge
  task automatic step(input logic [CW-1:0] c, input logic s, input logic [1:0] d,
                      input logic h);
    @(negedge clk);
    counterIn = c; rdStrobe = s; rdDomain = d; rdHigh = h;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R9: reset state
    #23;
    check("R9 reset valid", {31'd0, rdValid}, 32'd0);
    check("R9 reset data", rdData, 32'd0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].cnt, VEC[i].stb, VEC[i].dom, VEC[i].hi);
      check($sformatf("R%0d vec%0d valid", VEC[i].req, i), {31'd0, rdValid}, {31'd0, VEC[i].expV});
      check($sformatf("R%0d vec%0d data", VEC[i].req, i), rdData, VEC[i].expD);
    end

    // R9: reset clears a pending wrap bit (domain 0 is currently set)
    step(48'h0001_0000_0000, 1'b0, 2'd0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    step(48'h0001_0000_0001, 1'b1, 2'd0, 1'b1);
    check("R9 sticky cleared by reset", rdData, 32'h0000_0001);

    // R10: valid drops after a single strobe
    step(48'h0001_0000_0002, 1'b0, 2'd0, 1'b0);
    check("R10 valid low after strobe", {31'd0, rdValid}, 32'd0);

    // R4/R2: wrap carrying into the top counter bit
    step(48'h7FFF_FFFF_FFFF, 1'b0, 2'd1, 1'b0);
    step(48'h8000_0000_0000, 1'b0, 2'd1, 1'b0);
    step(48'h8000_0000_0001, 1'b1, 2'd1, 1'b1);
    check("R4 wrap at top bit", rdData, 32'h8000_8000);

    step(48'h8000_0000_0002, 1'b0, 2'd0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule